// File: doc/BRIEF.md
# Host Parallel Byte Port

This block is a slave byte port that lets an external host processor exchange single bytes with an internal controller. The host sees an 8-bit bus, one address line and active-low chip select, read and write strobes. These run with no relation to the internal clock. Address 0 reaches the data holding registers. Address 1 returns a status byte on reads and takes control bytes on writes. An interrupt output stays high while an outbound byte waits for the host.

On the internal side, host writes come out as a valid/ready byte stream. Each byte carries a flag that says whether it was written to the data address or the control address. The controller sends bytes to the host through a second valid/ready stream. Back-pressure works as follows. An inbound byte stays on `rx_data` with `rx_valid` high until `rx_ready` takes it. A host write that arrives while a byte is still pending is dropped, so the host must poll the busy flag first. `tx_ready` stays low from the moment a byte is loaded until the host reads it, so an unread byte is never overwritten.

All host strobes, the address and the bus pass through two-flop synchronisers. A write or read takes effect on the synchronised rising edge of its strobe, using the values the port sampled while the strobe was still low.

Top module: `host_byte_port`

## Requirements
- R1: After reset, `hst_irq` is 0, `rx_valid` is 0, `tx_ready` is 1, and a status read returns 0x80.
- R2: With `hst_addr`=1, a read returns the status byte: bit 7 is the outbound-empty flag (1 = nothing waiting for the host), bit 6 is the inbound-busy flag (1 = a byte is still pending internally, 0 = a new byte may be written), and bits 5..0 read 0. With `hst_addr`=0, a read returns the outbound holding byte.
- R3: `hst_doe` is 1 exactly while `hst_cs_n` and `hst_rd_n` are both 0.
- R4: When `tx_valid` and `tx_ready` are both high at a clock edge, the byte is stored, status bit 7 becomes 0, `hst_irq` becomes 1 and `tx_ready` becomes 0.
- R5: A completed host read at address 0 with chip select low sets status bit 7 back to 1 and drops `hst_irq` within 4 clock cycles of `hst_rd_n` rising. A status read does not do this.
- R6: A completed host write at address 0 with chip select low presents the byte on `rx_data` with `rx_valid`=1 and `rx_is_ctrl`=0 within 4 cycles of `hst_wr_n` rising. It also sets status bit 6. The byte and flag stay stable until `rx_ready` is high.
- R7: A completed host write at address 1 presents the byte with `rx_is_ctrl`=1.
- R8: A clock edge with `rx_valid` and `rx_ready` both high consumes the byte: `rx_valid` and status bit 6 return to 0.
- R9: While status bit 7 is 0, `tx_valid` has no effect: the outbound holding byte is unchanged.
- R10: A write strobe while `hst_cs_n` is high is ignored, and a host write while `rx_valid` is 1 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_cs_n | input | 1 | Host chip select, active low |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_addr | input | 1 | Host register select: 0 data, 1 status/control |
| hst_din | input | 8 | Host bus value seen by the port |
| hst_dout | output | 8 | Value to drive onto the host bus |
| hst_doe | output | 1 | Enable for the host bus driver |
| hst_irq | output | 1 | High while an outbound byte is waiting for the host |
| rx_valid | output | 1 | Inbound byte available |
| rx_ready | input | 1 | Internal side takes the inbound byte |
| rx_data | output | 8 | Inbound byte |
| rx_is_ctrl | output | 1 | Inbound byte came from the control address |
| tx_valid | input | 1 | Internal side offers an outbound byte |
| tx_ready | output | 1 | Outbound holding register is empty |
| tx_data | input | 8 | Outbound byte |

## Verification
A wrong flag register shows in two places: in the status byte on the next host read, and at once on `hst_irq`, `tx_ready` or `rx_valid`. The bench reads status after every transaction to catch it. A bad synchroniser or edge detector shows as a write or read that never takes effect, or that takes effect twice, within the four-cycle settling window. A lost second write and a missing second acceptance are both visible at the stream ports. Overwrite protection is checked by reading the held byte back through the host bus.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  // Status byte layout decoded by host software; positions are fixed.
  localparam int unsigned TE_POS = 7;
  localparam int unsigned RF_POS = 6;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_CTRL = 1'b1
  } hbp_sel_e;

  typedef struct packed {
    logic     wr_done;
    logic     rd_done;
    hbp_sel_e sel;
  } hbp_evt_t;
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbp_strobe_decode.sv
module hbp_strobe_decode
  import hbp_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              addr,
  input  logic [DATA_W-1:0] din,
  output hbp_evt_t          evt,
  output logic [DATA_W-1:0] wr_byte
);
  localparam int unsigned VW = DATA_W + 4;
  localparam logic [VW-1:0] IDLE = {1'b0, 1'b1, 1'b1, 1'b1, {DATA_W{1'b0}}};

  logic [VW-1:0] raw_v, syn_v, prv_v;

  assign raw_v = {addr, wr_n, rd_n, cs_n, din};

  hbp_sync #(.W(VW), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_v),
    .q    (syn_v)
  );

  // One more stage: the values seen while the strobe was still low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv_v <= IDLE;
    else        prv_v <= syn_v;
  end

  logic s_wr, s_rd, p_addr, p_wr, p_rd, p_cs;
  assign s_wr   = syn_v[DATA_W+2];
  assign s_rd   = syn_v[DATA_W+1];
  assign p_addr = prv_v[DATA_W+3];
  assign p_wr   = prv_v[DATA_W+2];
  assign p_rd   = prv_v[DATA_W+1];
  assign p_cs   = prv_v[DATA_W];

  always_comb begin
    evt.wr_done = s_wr & ~p_wr & ~p_cs;
    evt.rd_done = s_rd & ~p_rd & ~p_cs;
    evt.sel     = hbp_sel_e'(p_addr);
  end

  assign wr_byte = prv_v[DATA_W-1:0];
endmodule

// File: rtl/hbp_rx_hold.sv
module hbp_rx_hold
  import hbp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_done,
  input  hbp_sel_e          sel,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_is_ctrl
);
  logic              full;
  logic [DATA_W-1:0] hold;
  logic              ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
      ctrl <= 1'b0;
    end else if (wr_done && !full) begin
      full <= 1'b1;
      hold <= wr_byte;
      ctrl <= (sel == SEL_CTRL);
    end else if (full && rx_ready) begin
      full <= 1'b0;
    end
  end

  assign rx_valid   = full;
  assign rx_data    = hold;
  assign rx_is_ctrl = ctrl;

  // R6: pending byte is held steady under back-pressure
  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_is_ctrl)));

  // R7: an accepted host write makes a byte pending
  p_rx_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && !rx_valid) |=> rx_valid);

  // R8: a consumed byte with no new write leaves the stream idle
  p_rx_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_valid);
endmodule

// File: rtl/hbp_tx_hold.sv
module hbp_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              host_took,
  output logic              tx_ready,
  output logic              empty,
  output logic [DATA_W-1:0] hold
);
  logic te;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te   <= 1'b1;
      hold <= '0;
    end else if (tx_valid && te) begin
      te   <= 1'b0;
      hold <= tx_data;
    end else if (host_took) begin
      te <= 1'b1;
    end
  end

  assign empty    = te;
  assign tx_ready = te;

  // R9: a byte awaiting the host is never replaced
  p_no_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |=> $stable(hold));
endmodule

// File: rtl/host_byte_port.sv
module host_byte_port
  import hbp_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_cs_n,
  input  logic              hst_rd_n,
  input  logic              hst_wr_n,
  input  logic              hst_addr,
  input  logic [DATA_W-1:0] hst_din,
  output logic [DATA_W-1:0] hst_dout,
  output logic              hst_doe,
  output logic              hst_irq,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_is_ctrl,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data
);
  hbp_evt_t          evt;
  logic [DATA_W-1:0] wr_byte;
  logic [DATA_W-1:0] tx_hold;
  logic              te;
  logic              host_took;
  logic [DATA_W-1:0] status;

  hbp_strobe_decode #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (hst_cs_n),
    .rd_n   (hst_rd_n),
    .wr_n   (hst_wr_n),
    .addr   (hst_addr),
    .din    (hst_din),
    .evt    (evt),
    .wr_byte(wr_byte)
  );

  hbp_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_done   (evt.wr_done),
    .sel       (evt.sel),
    .wr_byte   (wr_byte),
    .rx_ready  (rx_ready),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_is_ctrl(rx_is_ctrl)
  );

  assign host_took = evt.rd_done && (evt.sel == SEL_DATA);

  hbp_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .host_took(host_took),
    .tx_ready (tx_ready),
    .empty    (te),
    .hold     (tx_hold)
  );

  always_comb begin
    status         = '0;
    status[TE_POS] = te;
    status[RF_POS] = rx_valid;
  end

  assign hst_irq  = ~te;
  assign hst_doe  = ~hst_cs_n & ~hst_rd_n;
  assign hst_dout = hst_addr ? status : tx_hold;

  // R4: loading an outbound byte raises the interrupt
  p_irq_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> hst_irq);

  // R5: host data read drops the interrupt
  p_irq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_took && !tx_ready) |=> !hst_irq);
endmodule

// File: tb/sim_host_byte_port.sv
module sim_host_byte_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hst_cs_n = 1'b1, hst_rd_n = 1'b1, hst_wr_n = 1'b1, hst_addr = 1'b0;
  logic [7:0] hst_din = 8'h00;
  logic [7:0] hst_dout;
  logic       hst_doe, hst_irq;
  logic       rx_valid, rx_is_ctrl, tx_ready;
  logic       rx_ready = 1'b0, tx_valid = 1'b0;
  logic [7:0] rx_data;
  logic [7:0] tx_data = 8'h00;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  host_byte_port u0 (
    .clk(clk), .rst_n(rst_n),
    .hst_cs_n(hst_cs_n), .hst_rd_n(hst_rd_n), .hst_wr_n(hst_wr_n),
    .hst_addr(hst_addr), .hst_din(hst_din), .hst_dout(hst_dout),
    .hst_doe(hst_doe), .hst_irq(hst_irq),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_is_ctrl(rx_is_ctrl),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_write(input logic a, input logic [7:0] d, input logic use_cs);
    @(negedge clk);
    hst_addr = a;
    hst_cs_n = ~use_cs;
    idle(1);
    hst_din  = d;
    hst_wr_n = 1'b0;
    idle(3);
    hst_wr_n = 1'b1;
    idle(1);
    hst_cs_n = 1'b1;
    idle(6);
  endtask

  task automatic host_read(input logic a, input logic use_cs, output logic [7:0] d, output logic oe);
    @(negedge clk);
    hst_addr = a;
    hst_cs_n = ~use_cs;
    idle(1);
    hst_rd_n = 1'b0;
    idle(2);
    d  = hst_dout;
    oe = hst_doe;
    hst_rd_n = 1'b1;
    idle(1);
    hst_cs_n = 1'b1;
    idle(6);
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_rx;
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic oe;
    chk("R1 irq", {7'b0, hst_irq}, 8'h00);
    chk("R1 rx_valid", {7'b0, rx_valid}, 8'h00);
    chk("R1 tx_ready", {7'b0, tx_ready}, 8'h01);
    chk("R3 idle doe", {7'b0, hst_doe}, 8'h00);
    host_read(1'b1, 1'b1, d, oe);
    chk("R1 status", d, 8'h80);
    chk("R3 doe during read", {7'b0, oe}, 8'h01);
  endtask

  task automatic t_tx_path;
    logic [7:0] d; logic oe;
    push_tx(8'hA5);
    chk("R4 irq", {7'b0, hst_irq}, 8'h01);
    chk("R4 tx_ready", {7'b0, tx_ready}, 8'h00);
    host_read(1'b1, 1'b1, d, oe);
    chk("R2 status pending", d, 8'h00);
    chk("R5 status read keeps irq", {7'b0, hst_irq}, 8'h01);
    host_read(1'b0, 1'b1, d, oe);
    chk("R2 data byte", d, 8'hA5);
    chk("R5 irq cleared", {7'b0, hst_irq}, 8'h00);
    chk("R5 tx_ready back", {7'b0, tx_ready}, 8'h01);
    host_read(1'b1, 1'b1, d, oe);
    chk("R5 status empty", d, 8'h80);
  endtask

  task automatic t_no_overwrite;
    logic [7:0] d; logic oe;
    push_tx(8'h11);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = 8'h22;
    idle(3);
    chk("R9 tx_ready low", {7'b0, tx_ready}, 8'h00);
    tx_valid = 1'b0;
    host_read(1'b0, 1'b1, d, oe);
    chk("R9 held byte", d, 8'h11);
  endtask

  task automatic t_rx_data;
    logic [7:0] d; logic oe;
    host_write(1'b0, 8'h5A, 1'b1);
    chk("R6 rx_valid", {7'b0, rx_valid}, 8'h01);
    chk("R6 rx_data", rx_data, 8'h5A);
    chk("R6 rx_is_ctrl", {7'b0, rx_is_ctrl}, 8'h00);
    host_read(1'b1, 1'b1, d, oe);
    chk("R6 status busy", d, 8'hC0);
    chk("R6 held", rx_data, 8'h5A);
    pop_rx();
    chk("R8 rx_valid drop", {7'b0, rx_valid}, 8'h00);
    host_read(1'b1, 1'b1, d, oe);
    chk("R8 status idle", d, 8'h80);
  endtask

  task automatic t_rx_ctrl;
    host_write(1'b1, 8'h7E, 1'b1);
    chk("R7 rx_valid", {7'b0, rx_valid}, 8'h01);
    chk("R7 rx_data", rx_data, 8'h7E);
    chk("R7 rx_is_ctrl", {7'b0, rx_is_ctrl}, 8'h01);
    pop_rx();
  endtask

  task automatic t_ignored;
    logic [7:0] d; logic oe;
    host_write(1'b0, 8'h33, 1'b0);
    chk("R10 no cs write", {7'b0, rx_valid}, 8'h00);
    host_read(1'b1, 1'b0, d, oe);
    chk("R3 no cs doe", {7'b0, oe}, 8'h00);
    host_write(1'b0, 8'h01, 1'b1);
    host_write(1'b0, 8'h02, 1'b1);
    chk("R10 first kept", rx_data, 8'h01);
    pop_rx();
    chk("R10 second dropped", {7'b0, rx_valid}, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_tx_path();
    t_no_overwrite();
    t_rx_data();
    t_rx_ctrl();
    t_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule